// File: doc/BRIEF.md
# Machine-Check Interruption Store Sequencer

This block performs the storage side of a machine-check interruption in hardware. A one-cycle start pulse captures three things: a flag that says whether a failing storage address exists, the failing address itself, and the 8-byte interruption code. The sequencer then writes the interrupted status word and the register save areas to fixed low-storage locations. It writes the failing address if there is one, then the interruption code. Last, it reads the new status word.

All traffic goes through a single request/acknowledge memory port. The port moves 8 bytes per beat and reports an error with each acknowledge. Save data comes from an external register source. The sequencer drives a source index, and the source returns the matching 64-bit word in the same cycle.

A failed interruption-code store or a failed new-word fetch puts the block into a terminal check-stop state. A failed write to any other location is only recorded, and the sequence carries on.

Top module: `mck_store_seq`

## Requirements
- R1: Save beats come first and use a full byte mask (8'hFF), with write data taken from source index equal to the beat number (0 to 22). Beat 0 goes to byte address 48. Beats 1 and 2 go to 216 and 224. Beats 3 to 22 go to 352 + 8*(beat-3), which covers 352 up to 504.
- R2: When the captured flag is set, beat 23 writes the failing address to byte address 248. It uses mask 8'h0F, where mask bit k enables byte address+k carried on data bits 8k+7:8k. The address sits in data bits 31:0 and bits 63:32 are zero. When the flag is clear, this beat is skipped.
- R3: After the save area (and the failing address, if present), one write goes to 232 with the interruption code and mask 8'hFF. After that comes one read (write-enable low) from 112, and it is the final request.
- R4: Only one request is outstanding at a time. The address, data, mask and write-enable stay stable while the request waits for acknowledge. The request drops in the cycle after an acknowledge.
- R5: An error acknowledge on the interruption-code write or on the new-word read sets stopped_o. No further request is then issued, and stopped_o stays set until reset.
- R6: An error acknowledge on any other write sets save_err_o, which stays set until reset. The remaining beats are still issued.
- R7: A successful read ends the sequence. In the cycle after its acknowledge, done_o is high for exactly one cycle and new_sw_o holds the read data.
- R8: A start pulse has no effect while the block is busy or stopped: no extra request is issued.
- R9: After reset the block issues no request, and busy_o, done_o, stopped_o and save_err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an interruption store sequence |
| fa_vld_i | input | 1 | A failing storage address exists |
| fail_addr_i | input | 32 | Failing storage address |
| code_i | input | 64 | Interruption code to store |
| src_idx_o | output | 5 | Register source index for the next save beat |
| src_data_i | input | 64 | Register source word for src_idx_o |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Byte address of the beat |
| mem_be_o | output | 8 | Byte enables |
| mem_wdata_o | output | 64 | Write data |
| mem_ack_i | input | 1 | Request accepted |
| mem_err_i | input | 1 | Error response, valid with ack |
| mem_rdata_i | input | 64 | Read data, valid with ack |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_sw_o | output | 64 | Fetched new status word |
| stopped_o | output | 1 | Check-stop state |
| save_err_o | output | 1 | A non-critical write failed |

## Verification
The bench builds the block with ADDR_W set to 16 instead of the default 12. This shows that the fixed low-storage addresses are zero-extended correctly into a wider port. The memory model's acknowledge latency varies from zero to three wait cycles, so both back-to-back acknowledges and long held requests are covered. An error can be injected on any beat number. This reaches both critical failure points with and without the failing-address beat, as well as error-tolerant save, old-word and failing-address writes.

// File: rtl/mck_pkg.sv
package mck_pkg;

    localparam int BEAT_W  = 64;
    localparam int BE_W    = BEAT_W / 8;
    localparam int FA_W    = 32;
    localparam int PLAN_AW = 10;
    localparam int STEP_W  = 5;

    localparam int N_SAVE     = 23;
    localparam int STEP_FA    = N_SAVE;
    localparam int STEP_CODE  = N_SAVE + 1;
    localparam int STEP_FETCH = N_SAVE + 2;

    localparam logic [PLAN_AW-1:0] LOC_OLD_SW = 10'd48;
    localparam logic [PLAN_AW-1:0] LOC_TIMER  = 10'd216;
    localparam logic [PLAN_AW-1:0] LOC_CMP    = 10'd224;
    localparam logic [PLAN_AW-1:0] LOC_CODE   = 10'd232;
    localparam logic [PLAN_AW-1:0] LOC_FAIL   = 10'd248;
    localparam logic [PLAN_AW-1:0] LOC_REGS   = 10'd352;
    localparam logic [PLAN_AW-1:0] LOC_NEW_SW = 10'd112;

    typedef enum logic [1:0] {K_SAVE, K_FAIL, K_CODE, K_FETCH} step_kind_e;
    typedef enum logic [1:0] {S_IDLE, S_LOAD, S_REQ, S_STOP} seq_state_e;

    typedef struct packed {
        step_kind_e          kind;
        logic [PLAN_AW-1:0]  addr;
        logic [BE_W-1:0]     be;
        logic                we;
    } step_desc_t;

    // Address of a save-area beat; beats 3..22 form one contiguous run.
    function automatic logic [PLAN_AW-1:0] save_loc(logic [STEP_W-1:0] idx);
        logic [PLAN_AW-1:0] off;
        off = {2'b00, idx - 5'd3, 3'b000};
        case (idx)
            5'd0:    return LOC_OLD_SW;
            5'd1:    return LOC_TIMER;
            5'd2:    return LOC_CMP;
            default: return LOC_REGS + off;
        endcase
    endfunction

    function automatic step_desc_t describe(logic [STEP_W-1:0] idx);
        step_desc_t d;
        d.kind = K_SAVE;
        d.addr = save_loc(idx);
        d.be   = '1;
        d.we   = 1'b1;
        if (idx == STEP_W'(STEP_FA)) begin
            d.kind = K_FAIL;
            d.addr = LOC_FAIL;
            d.be   = BE_W'((1 << (FA_W / 8)) - 1);
        end else if (idx == STEP_W'(STEP_CODE)) begin
            d.kind = K_CODE;
            d.addr = LOC_CODE;
        end else if (idx == STEP_W'(STEP_FETCH)) begin
            d.kind = K_FETCH;
            d.addr = LOC_NEW_SW;
            d.we   = 1'b0;
        end
        return d;
    endfunction

endpackage

// File: rtl/mck_step_plan.sv
module mck_step_plan
    import mck_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic              fa_vld,
    output step_desc_t        desc,
    output logic [STEP_W-1:0] next_step
);
    logic [STEP_W-1:0] inc;

    always_comb begin
        desc = describe(step);
        inc  = step + 5'd1;
        if (inc == STEP_W'(STEP_FA) && !fa_vld)
            next_step = STEP_W'(STEP_CODE);
        else
            next_step = inc;
    end
endmodule

// File: rtl/mck_beat_reg.sv
module mck_beat_reg
    import mck_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  step_desc_t         desc,
    input  logic [BEAT_W-1:0]  src_data,
    input  logic [FA_W-1:0]    fail_addr,
    input  logic [BEAT_W-1:0]  code,
    input  logic               ack,
    output logic               req,
    output logic               we,
    output logic [ADDR_W-1:0]  addr,
    output logic [BE_W-1:0]    be,
    output logic [BEAT_W-1:0]  wdata
);
    logic [BEAT_W-1:0] pick;

    always_comb begin
        case (desc.kind)
            K_SAVE:  pick = src_data;
            K_FAIL:  pick = {{(BEAT_W-FA_W){1'b0}}, fail_addr};
            K_CODE:  pick = code;
            default: pick = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req   <= 1'b0;
            we    <= 1'b0;
            addr  <= '0;
            be    <= '0;
            wdata <= '0;
        end else if (load) begin
            req   <= 1'b1;
            we    <= desc.we;
            addr  <= ADDR_W'(desc.addr);
            be    <= desc.be;
            wdata <= pick;
        end else if (req && ack) begin
            req   <= 1'b0;
        end
    end

    // R4: a waiting request keeps every field steady
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        req && !ack |=> req && $stable(addr) && $stable(wdata) && $stable(be) && $stable(we));

    // R4: request withdrawn after acknowledge
    a_r4_drop: assert property (@(posedge clk) disable iff (rst)
        req && ack |=> !req);
endmodule

// File: rtl/mck_store_seq.sv
module mck_store_seq
    import mck_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               fa_vld_i,
    input  logic [31:0]        fail_addr_i,
    input  logic [63:0]        code_i,
    output logic [4:0]         src_idx_o,
    input  logic [63:0]        src_data_i,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [7:0]         mem_be_o,
    output logic [63:0]        mem_wdata_o,
    input  logic               mem_ack_i,
    input  logic               mem_err_i,
    input  logic [63:0]        mem_rdata_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [63:0]        new_sw_o,
    output logic               stopped_o,
    output logic               save_err_o
);
    seq_state_e          state;
    logic [STEP_W-1:0]   step;
    logic [STEP_W-1:0]   next_step;
    step_desc_t          desc;
    logic                fa_vld_q;
    logic [FA_W-1:0]     fail_addr_q;
    logic [BEAT_W-1:0]   code_q;
    logic                load;
    logic                critical;

    mck_step_plan u_plan (
        .step      (step),
        .fa_vld    (fa_vld_q),
        .desc      (desc),
        .next_step (next_step)
    );

    assign load = (state == S_LOAD);

    mck_beat_reg #(.ADDR_W(ADDR_W)) u_beat (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .desc      (desc),
        .src_data  (src_data_i),
        .fail_addr (fail_addr_q),
        .code      (code_q),
        .ack       (mem_ack_i),
        .req       (mem_req_o),
        .we        (mem_we_o),
        .addr      (mem_addr_o),
        .be        (mem_be_o),
        .wdata     (mem_wdata_o)
    );

    assign critical  = (desc.kind == K_CODE) || (desc.kind == K_FETCH);
    assign src_idx_o = step;
    assign busy_o    = (state == S_LOAD) || (state == S_REQ);
    assign stopped_o = (state == S_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            step        <= '0;
            fa_vld_q    <= 1'b0;
            fail_addr_q <= '0;
            code_q      <= '0;
            done_o      <= 1'b0;
            new_sw_o    <= '0;
            save_err_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                S_IDLE: if (start_i) begin
                    fa_vld_q    <= fa_vld_i;
                    fail_addr_q <= fail_addr_i;
                    code_q      <= code_i;
                    step        <= '0;
                    state       <= S_LOAD;
                end
                S_LOAD: state <= S_REQ;
                S_REQ: if (mem_ack_i) begin
                    if (mem_err_i && critical) begin
                        state <= S_STOP;
                    end else begin
                        if (mem_err_i)
                            save_err_o <= 1'b1;
                        if (desc.kind == K_FETCH) begin
                            done_o   <= 1'b1;
                            new_sw_o <= mem_rdata_i;
                            state    <= S_IDLE;
                        end else begin
                            step  <= next_step;
                            state <= S_LOAD;
                        end
                    end
                end
                default: state <= S_STOP;
            endcase
        end
    end

    // R5: check-stop is terminal until reset
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        stopped_o |=> stopped_o);
    // R5: no traffic once stopped
    a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
        stopped_o |-> !mem_req_o);
    // R6: save error flag never clears by itself
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        save_err_o |=> save_err_o);
    // R7: completion is a single-cycle pulse
    a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    // R2: the partial mask is only used for the failing address
    a_r2_mask: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && mem_we_o && mem_be_o != 8'hFF
            |-> mem_addr_o == ADDR_W'(248) && mem_be_o == 8'h0F);
    // R3: the only read is the new-word fetch
    a_r3_fetch: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_we_o |-> mem_addr_o == ADDR_W'(112));
    // R8: start while stopped leaves the block stopped and idle
    a_r8_stopped: assert property (@(posedge clk) disable iff (rst)
        stopped_o && start_i |=> !busy_o);
endmodule

// File: tb/mck_store_seq_bench.sv
module mck_store_seq_bench;
    localparam int AW = 16;
    localparam logic [63:0] NEW_SW = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] CODE   = 64'hFEED_0000_BEEF_1111;
    localparam logic [31:0] FADDR  = 32'h00AB_CDE0;

    // {fa_vld, fault beat (31 = none), latency, expect stop, expect save_err}
    localparam int NV = 9;
    localparam logic [9:0] VEC [NV] = '{
        {1'b1, 5'd31, 2'd0, 1'b0, 1'b0},
        {1'b0, 5'd31, 2'd2, 1'b0, 1'b0},
        {1'b1, 5'd5,  2'd1, 1'b0, 1'b1},
        {1'b1, 5'd24, 2'd0, 1'b1, 1'b0},
        {1'b0, 5'd24, 2'd1, 1'b1, 1'b0},
        {1'b1, 5'd25, 2'd0, 1'b1, 1'b0},
        {1'b1, 5'd0,  2'd3, 1'b0, 1'b1},
        {1'b0, 5'd23, 2'd0, 1'b1, 1'b0},
        {1'b1, 5'd23, 2'd1, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, fa_vld_i = 1'b0;
    logic [31:0] fail_addr_i = FADDR;
    logic [63:0] code_i = CODE;
    logic [4:0]  src_idx_o;
    logic [63:0] src_data_i;
    logic mem_req_o, mem_we_o, mem_ack_i, mem_err_i;
    logic [AW-1:0] mem_addr_o;
    logic [7:0]  mem_be_o;
    logic [63:0] mem_wdata_o, mem_rdata_i;
    logic busy_o, done_o, stopped_o, save_err_o;
    logic [63:0] new_sw_o;

    int checks = 0, errors = 0, cycles = 0;
    int cur_lat = 0, cur_fault = 31, wcnt = 0, nlog = 0;
    logic [AW-1:0] log_addr [32];
    logic          log_we   [32];
    logic [7:0]    log_be   [32];
    logic [63:0]   log_data [32];
    logic          got_done;
    logic [63:0]   got_sw;

    always #5 clk = ~clk;

    function automatic logic [63:0] srcval(logic [4:0] i);
        return 64'h5A00_0000_0000_0000 | ({59'd0, i} * 64'h0001_0003_0007_000B);
    endfunction
    assign src_data_i = srcval(src_idx_o);

    mck_store_seq #(.ADDR_W(AW)) u_mck_store_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .fa_vld_i(fa_vld_i),
        .fail_addr_i(fail_addr_i), .code_i(code_i), .src_idx_o(src_idx_o),
        .src_data_i(src_data_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
        .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .new_sw_o(new_sw_o),
        .stopped_o(stopped_o), .save_err_o(save_err_o)
    );

    // memory model, moves on the falling edge
    always @(negedge clk) begin
        if (rst) begin
            mem_ack_i = 1'b0; mem_err_i = 1'b0; mem_rdata_i = '0;
            wcnt = 0; nlog = 0;
        end else if (mem_ack_i) begin
            mem_ack_i = 1'b0; mem_err_i = 1'b0;
        end else if (mem_req_o) begin
            if (wcnt >= cur_lat) begin
                if (nlog < 32) begin
                    log_addr[nlog] = mem_addr_o; log_we[nlog] = mem_we_o;
                    log_be[nlog]   = mem_be_o;   log_data[nlog] = mem_wdata_o;
                end
                mem_ack_i   = 1'b1;
                mem_err_i   = (nlog == cur_fault);
                mem_rdata_i = NEW_SW;
                nlog++;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
        end
    endtask

    task automatic chk(logic ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(2); rst = 1'b0; tick(1);
    endtask

    task automatic run_seq(logic fa, int fault, int lat, logic extra_start);
        cur_fault = fault; cur_lat = lat; fa_vld_i = fa;
        got_done = 1'b0; got_sw = '0;
        start_i = 1'b1; tick(1); start_i = 1'b0; fa_vld_i = ~fa;
        for (int i = 0; i < 400; i++) begin
            if (extra_start && i == 20) start_i = 1'b1;
            if (extra_start && i == 21) start_i = 1'b0;
            if (done_o) begin
                got_done = 1'b1; got_sw = new_sw_o;
                tick(1);
                chk(!done_o, "R7 pulse width", {63'd0, done_o}, 64'd0);
                break;
            end
            if (stopped_o) break;
            tick(1);
        end
        tick(12);
    endtask

    task automatic check_beats(logic fa, int n);
        for (int b = 0; b < n && b < 32; b++) begin
            logic [AW-1:0] ea;
            logic ewe;
            logic [7:0] ebe;
            logic [63:0] ed;
            string tag;
            ewe = 1'b1; ebe = 8'hFF;
            if (b < 23) begin
                tag = "R1 save beat";
                ed  = srcval(5'(b));
                if (b == 0) ea = 16'd48;
                else if (b == 1) ea = 16'd216;
                else if (b == 2) ea = 16'd224;
                else ea = AW'(352 + 8 * (b - 3));
            end else if (fa && b == 23) begin
                tag = "R2 failing address"; ea = 16'd248; ebe = 8'h0F; ed = {32'd0, FADDR};
            end else if (b == (fa ? 24 : 23)) begin
                tag = "R3 code store"; ea = 16'd232; ed = CODE;
            end else begin
                tag = "R3 new word read"; ea = 16'd112; ewe = 1'b0; ebe = log_be[b];
                ed = log_data[b];
            end
            chk({log_addr[b], log_we[b], log_be[b]} == {ea, ewe, ebe}, tag,
                {39'd0, log_addr[b], log_we[b], log_be[b]}, {39'd0, ea, ewe, ebe});
            chk(log_data[b] == ed, tag, log_data[b], ed);
        end
    endtask

    initial begin
        mem_ack_i = 1'b0; mem_err_i = 1'b0; mem_rdata_i = '0;
        do_reset();
        // R9 reset state
        chk({mem_req_o, busy_o, done_o, stopped_o, save_err_o} == 5'b0, "R9 reset",
            {59'd0, mem_req_o, busy_o, done_o, stopped_o, save_err_o}, 64'd0);
        tick(3);
        chk(!mem_req_o, "R9 no request", {63'd0, mem_req_o}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            logic fa, est, eer;
            int fault, lat, full, nexp;
            fa = VEC[v][9]; fault = int'(VEC[v][8:4]); lat = int'(VEC[v][3:2]);
            est = VEC[v][1]; eer = VEC[v][0];
            full = fa ? 26 : 25;
            nexp = est ? fault + 1 : full;
            do_reset();
            run_seq(fa, fault, lat, 1'b0);
            chk(nlog == nexp, "R5 beat count", 64'(nlog), 64'(nexp));
            check_beats(fa, nlog);
            chk(stopped_o == est, "R5 stop state", {63'd0, stopped_o}, {63'd0, est});
            chk(save_err_o == eer, "R6 save error", {63'd0, save_err_o}, {63'd0, eer});
            chk(got_done == !est, "R7 done seen", {63'd0, got_done}, {63'd0, !est});
            if (!est) chk(got_sw == NEW_SW, "R7 new word", got_sw, NEW_SW);
            if (est) begin
                // R8: start ignored while stopped
                start_i = 1'b1; tick(1); start_i = 1'b0; tick(10);
                chk(nlog == nexp, "R8 start while stopped", 64'(nlog), 64'(nexp));
                chk(stopped_o, "R5 stays stopped", {63'd0, stopped_o}, 64'd1);
            end
        end

        // R8: start while busy is ignored
        do_reset();
        run_seq(1'b0, 31, 2, 1'b1);
        chk(nlog == 25, "R8 start while busy", 64'(nlog), 64'd25);
        chk(got_done, "R7 done after busy start", {63'd0, got_done}, 64'd1);

        // R5/R9: reset clears check-stop
        do_reset();
        run_seq(1'b1, 24, 0, 1'b0);
        rst = 1'b1; tick(1); rst = 1'b0; tick(1);
        chk(!stopped_o && !busy_o, "R9 reset clears stop",
            {62'd0, stopped_o, busy_o}, 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule